// File: doc/BRIEF.md
# Up/Down Counter with Load

A small synchronous binary counter that steps up or down by one on each clock edge where it is enabled. It carries an asynchronous clear, a synchronous parallel preset with an active-low strobe, an active-low run input, and an active-low terminal-count output. The terminal output goes low on the value where the next step would wrap: all ones when stepping up, all zeros when stepping down.

The terminal output is combinational from the held value and the direction input. This lets instances be chained into wider counters by feeding one stage's terminal output into the next stage's run input. The same output can also drive the counter's own preset strobe, so the count wraps to a chosen start value instead of zero. An external compare on the count that drives the preset strobe limits the top of the range. The width is a parameter and defaults to four bits.

Top module: `updn_load_counter`

## Requirements
- R1: While `wipe` is 1 the count is 0, and it reaches 0 as soon as `wipe` rises, before any clock edge.
- R2: With `wipe` 0 and `preset_n` 0 at a clock edge, the count takes `preset_val` after that edge, whatever `run_n` and `count_up` are.
- R3: With `wipe` 0, `preset_n` 1, `run_n` 0 and `count_up` 1, each edge adds one modulo 2^WIDTH, so all ones is followed by 0.
- R4: With `wipe` 0, `preset_n` 1, `run_n` 0 and `count_up` 0, each edge subtracts one modulo 2^WIDTH, so 0 is followed by all ones.
- R5: With `wipe` 0, `preset_n` 1 and `run_n` 1, the count does not change at the edge.
- R6: `term_n` is 0 exactly when `count_up` is 1 and the count is all ones, or `count_up` is 0 and the count is 0. Otherwise it is 1. It follows a change of `count_up` without a clock edge.
- R7: Clear has priority over preset: with `wipe` 1 and `preset_n` 0 the count stays 0.
- R8: Two instances, with the low one's `term_n` driving the high one's `run_n` and a shared clock and clear, count up through all 256 values of the 8-bit pair. The high instance advances only on the edge where the low instance passes all ones.
- R9: With `term_n` wired to `preset_n`, `preset_val` = 6, up counting and `run_n` 0, the count goes from 15 to 6 and then repeats 6 to 15.
- R10: With `preset_val` = 0 and `preset_n` driven low when the count equals 12 (binary 1100), up counting cycles through 0 to 12 only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| wipe | input | 1 | Asynchronous clear, active high |
| count_up | input | 1 | Direction: 1 steps up, 0 steps down |
| preset_n | input | 1 | Synchronous preset strobe, active low |
| run_n | input | 1 | Count enable, active low |
| preset_val | input | WIDTH | Value taken on a preset |
| count | output | WIDTH | Registered count |
| term_n | output | 1 | Terminal count for the current direction, active low |

## Verification
The assertions assume the control inputs change only away from the rising clock edge. They also assume `wipe` is held for at least one full clock period when asserted, so each property sees a stable previous cycle. The stimulus drives every input on the falling edge. The one exception is the mid-cycle clear, which rises after a falling edge and stays high across the next rising edge. The step checks also assume the preset and run inputs are known at each edge, and the bench never leaves them undriven after time zero.

// File: rtl/updn_load_counter_pkg.sv
package updn_load_counter_pkg;

  // Action chosen for the next clock edge (clear is asynchronous and not listed)
  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_INC  = 2'd2,
    ACT_DEC  = 2'd3
  } step_act_e;

endpackage

// File: rtl/updn_act_decode.sv
module updn_act_decode
  import updn_load_counter_pkg::*;
(
  input  logic      preset_n,
  input  logic      run_n,
  input  logic      count_up,
  output step_act_e act
);

  // Preset wins over the run input; direction matters only when running
  always_comb begin
    if (!preset_n)      act = ACT_LOAD;
    else if (run_n)     act = ACT_KEEP;
    else if (count_up)  act = ACT_INC;
    else                act = ACT_DEC;
  end

endmodule

// File: rtl/updn_next_value.sv
module updn_next_value
  import updn_load_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  step_act_e        act,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

  always_comb begin
    case (act)
      ACT_LOAD: nxt = load_val;
      ACT_INC:  nxt = cur + STEP;
      ACT_DEC:  nxt = cur - STEP;
      default:  nxt = cur;
    endcase
  end

endmodule

// File: rtl/updn_term_detect.sv
module updn_term_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             count_up,
  output logic             term_n
);

  logic all_ones;
  logic all_zero;

  assign all_ones = &cur;
  assign all_zero = ~|cur;

  // Low on the value at which the next step in this direction wraps
  assign term_n = count_up ? ~all_ones : ~all_zero;

endmodule

// File: rtl/updn_load_counter.sv
module updn_load_counter
  import updn_load_counter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             wipe,
  input  logic             count_up,
  input  logic             preset_n,
  input  logic             run_n,
  input  logic [WIDTH-1:0] preset_val,
  output logic [WIDTH-1:0] count,
  output logic             term_n
);

  step_act_e        act;
  logic [WIDTH-1:0] nxt;

  updn_act_decode u_decode (
    .preset_n (preset_n),
    .run_n    (run_n),
    .count_up (count_up),
    .act      (act)
  );

  updn_next_value #(.WIDTH(WIDTH)) u_next (
    .act      (act),
    .cur      (count),
    .load_val (preset_val),
    .nxt      (nxt)
  );

  always_ff @(posedge clk or posedge wipe) begin
    if (wipe) count <= '0;
    else      count <= nxt;
  end

  updn_term_detect #(.WIDTH(WIDTH)) u_term (
    .cur      (count),
    .count_up (count_up),
    .term_n   (term_n)
  );

endmodule

// File: rtl/updn_load_counter_chk.sv
module updn_load_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             wipe,
  input logic             count_up,
  input logic             preset_n,
  input logic             run_n,
  input logic [WIDTH-1:0] preset_val,
  input logic [WIDTH-1:0] count,
  input logic             term_n
);

  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] ONES = '1;

  // R1
  clear_holds_zero_chk: assert property (@(posedge clk)
    ($past(wipe) && wipe) |-> (count == '0));

  // R7
  clear_beats_preset_chk: assert property (@(posedge clk)
    ($past(wipe) && !$past(preset_n)) |-> (count == '0));

  // R2
  preset_takes_value_chk: assert property (@(posedge clk) disable iff (wipe)
    (!$past(wipe) && !$past(preset_n)) |-> (count == $past(preset_val)));

  // R3
  step_up_chk: assert property (@(posedge clk) disable iff (wipe)
    (!$past(wipe) && $past(preset_n) && !$past(run_n) && $past(count_up))
      |-> (count == $past(count) + ONE));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (wipe)
    (!$past(wipe) && $past(preset_n) && !$past(run_n) && !$past(count_up))
      |-> (count == $past(count) - ONE));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (wipe)
    (!$past(wipe) && $past(preset_n) && $past(run_n)) |-> $stable(count));

  // R6
  term_up_wraps_chk: assert property (@(posedge clk) disable iff (wipe)
    (!$past(wipe) && !$past(term_n) && $past(preset_n) && !$past(run_n) && $past(count_up))
      |-> (count == '0));

  // R6
  term_down_wraps_chk: assert property (@(posedge clk) disable iff (wipe)
    (!$past(wipe) && !$past(term_n) && $past(preset_n) && !$past(run_n) && !$past(count_up))
      |-> (count == ONES));

endmodule

bind updn_load_counter updn_load_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .wipe       (wipe),
  .count_up   (count_up),
  .preset_n   (preset_n),
  .run_n      (run_n),
  .preset_val (preset_val),
  .count      (count),
  .term_n     (term_n)
);

// File: tb/test_updn_load_counter.sv
`timescale 1ns/1ps
module test_updn_load_counter;

  logic       clk = 1'b0;
  logic       wipe = 1'b1;
  logic       count_up = 1'b1;
  logic       preset_n = 1'b1;
  logic       run_n = 1'b1;
  logic [3:0] preset_val = 4'd0;
  logic [3:0] count;
  logic       term_n;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  updn_load_counter #(.WIDTH(4)) i_updn_load_counter (
    .clk(clk), .wipe(wipe), .count_up(count_up), .preset_n(preset_n),
    .run_n(run_n), .preset_val(preset_val), .count(count), .term_n(term_n)
  );

  // 8-bit cascade: low stage terminal output enables high stage (R8)
  logic       cas_run_n = 1'b1;
  logic [3:0] cas_lo, cas_hi;
  logic       cas_lo_term, cas_hi_term;
  updn_load_counter #(.WIDTH(4)) i_cas_lo (
    .clk(clk), .wipe(wipe), .count_up(1'b1), .preset_n(1'b1), .run_n(cas_run_n),
    .preset_val(4'd0), .count(cas_lo), .term_n(cas_lo_term)
  );
  updn_load_counter #(.WIDTH(4)) i_cas_hi (
    .clk(clk), .wipe(wipe), .count_up(1'b1), .preset_n(1'b1), .run_n(cas_lo_term),
    .preset_val(4'd0), .count(cas_hi), .term_n(cas_hi_term)
  );

  // Terminal output fed back as preset strobe, preset value 6 (R9)
  logic [3:0] wrap_q;
  logic       wrap_term;
  updn_load_counter #(.WIDTH(4)) i_wrap (
    .clk(clk), .wipe(wipe), .count_up(1'b1), .preset_n(wrap_term), .run_n(1'b0),
    .preset_val(4'd6), .count(wrap_q), .term_n(wrap_term)
  );

  // Compare on 12 drives a preset of 0 (R10)
  logic [3:0] lim_q;
  logic       lim_term;
  logic       lim_hit_n;
  assign lim_hit_n = ~(lim_q[3] & lim_q[2] & ~lim_q[1] & ~lim_q[0]);
  updn_load_counter #(.WIDTH(4)) i_lim (
    .clk(clk), .wipe(wipe), .count_up(1'b1), .preset_n(lim_hit_n), .run_n(1'b0),
    .preset_val(4'd0), .count(lim_q), .term_n(lim_term)
  );

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // Reference models
  int m_main = 0, m_cas = 0, m_wrap = 0, m_lim = 0;

  function automatic string step_req();
    if (wipe)          return (!preset_n) ? "R7" : "R1";
    if (!preset_n)     return "R2";
    if (run_n)         return "R5";
    return count_up ? "R3" : "R4";
  endfunction

  always @(posedge clk) begin
    string r;
    r = step_req();
    if (wipe) begin
      m_main = 0; m_cas = 0; m_wrap = 0; m_lim = 0;
    end else begin
      if (!preset_n)     m_main = preset_val;
      else if (!run_n)   m_main = count_up ? (m_main + 1) % 16 : (m_main + 15) % 16;
      if (!cas_run_n)    m_cas = (m_cas + 1) % 256;
      m_wrap = (m_wrap == 15) ? 6 : m_wrap + 1;
      m_lim  = (m_lim == 12) ? 0 : m_lim + 1;
    end
    #2;
    if (!finished) begin
      check(r, count, m_main);
      check("R6", term_n, (count_up ? (m_main == 15) : (m_main == 0)) ? 0 : 1);
      check("R8", {cas_hi, cas_lo}, m_cas);
      check("R9", wrap_q, m_wrap);
      check("R10", lim_q, m_lim);
    end
  end

  task automatic drive(input bit w, input bit up, input bit pn, input bit rn, input int v);
    @(negedge clk);
    wipe = w; count_up = up; preset_n = pn; run_n = rn; preset_val = 4'(v);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1", count, 0);          // reset state
    check("R6", term_n, 1);         // count 0, stepping up
    drive(0, 1, 1, 1, 0);           // hold (R5)
    repeat (2) drive(0, 1, 1, 1, 9);
    drive(0, 1, 1, 0, 0);           // count up, wrap through 15 (R3)
    repeat (20) drive(0, 1, 1, 0, 0);
    drive(0, 0, 1, 0, 0);           // count down, wrap through 0 (R4)
    repeat (20) drive(0, 0, 1, 0, 0);
    drive(0, 1, 0, 1, 11);          // preset while idle (R2)
    drive(0, 0, 0, 0, 3);           // preset while running down (R2)
    drive(0, 1, 1, 1, 0);
    drive(0, 1, 0, 1, 15);          // preset 15 for direction test
    drive(0, 1, 1, 1, 0);
    @(negedge clk); #1;
    check("R6", term_n, 0);         // 15 while up
    count_up = 1'b0; #1;
    check("R6", term_n, 1);         // same value, now down, no edge
    count_up = 1'b1;
    // Mid-cycle clear, no clock edge yet (R1)
    @(negedge clk); #1;
    wipe = 1'b1; #1;
    check("R1", count, 0);
    drive(1, 1, 0, 0, 13);          // clear beats preset (R7)
    drive(1, 0, 0, 1, 7);
    drive(0, 1, 1, 1, 0);
    // Cascade, wrap and limit configurations run together
    drive(0, 1, 1, 1, 0);
    cas_run_n = 1'b0;
    repeat (600) drive(0, 1, 1, 1, 0);
    cas_run_n = 1'b1;
    repeat (3) drive(0, 1, 1, 1, 0);
    @(negedge clk);
    finish_run();
  end

endmodule